// File: doc/BRIEF.md
# Sleep Stage Classifier

This block follows a sleeper through five stages (Wake, REM, N1, N2 and N3) and decides the next stage with threshold comparisons only. An upstream feature extractor presents a packed vector of unsigned feature fields with a one-cycle valid strobe. A set of programmable thresholds, one for each pairing of a current stage with a candidate stage, is held on a wide input bus. The block starts a reclassification only when an accepted vector differs from the last accepted one.

A reclassification is a short sequence of one-versus-one tests, one per clock. The current stage selects which candidate stages are tried and in what order. Each test compares one feature field, chosen by the candidate stage, against the threshold held for that position in the sequence. The first candidate that wins becomes the new stage, and a one-cycle pulse marks the change. If no candidate wins, the stage is kept and no pulse is issued.

Top module: `sleep_stager`

## Requirements
- R1: While rstN is low and after it is released, stage reads Wake and stageChanged is 0.
- R2: stage is a 3-bit code: Wake=0, REM=1, N1=2, N2=3, N3=4. No other value ever appears.
- R3: A featValid cycle starts a reclassification only if featVec differs from the last accepted vector. The last accepted vector is all zero after reset. An equal vector leaves stage unchanged and gives no pulse.
- R4: featValid is ignored while a reclassification is running. Such a vector is neither classified nor recorded as the last accepted vector.
- R5: Candidate order by current stage. From Wake: N1, REM, N2, N3. From REM: Wake, N1, N2, N3. From N1: Wake, N2, REM, N3. From N2: N1, N3, REM, Wake. From N3: N2, N1, Wake, REM. The test at position p (0..3) from current stage code c uses threshold slot c*4+p, which is thrVec[(c*4+p)*FEAT_W +: FEAT_W].
- R6: The test for candidate code k reads feature field k mod NUM_FEAT, which is featVec[f*FEAT_W +: FEAT_W]. The candidate wins when that field is strictly greater than the threshold, both compared unsigned. The feature vector is the one captured at acceptance.
- R7: One test is made per clock, and the first winning test ends the sequence. If a vector is accepted at clock edge k and position p wins, stage takes the new code right after edge k+1+p.
- R8: If none of the four tests wins, stage keeps its value and stageChanged stays 0.
- R9: stageChanged is high for exactly one cycle, in the cycle where stage first shows a new code. It is never high when stage has not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| featValid | input | 1 | Strobe marking featVec as a fresh feature vector |
| featVec | input | FEAT_W*NUM_FEAT | Packed unsigned feature fields, field 0 in the low bits |
| thrVec | input | FEAT_W*20 | Packed unsigned thresholds, slot s at bits s*FEAT_W |
| stage | output | 3 | Current stage code |
| stageChanged | output | 1 | One-cycle pulse when a new stage is committed |

## Verification
Directed patterns come first. With every threshold at zero, a repeated vector shows whether the change filter works, because any accepted vector would otherwise win the first test. With every threshold at maximum, the block must hold the stage through all four tests. A vector sent in the middle of that run is used to tell a dropped strobe from an accepted one. A single opened threshold slot shows that the right position and feature field are tested in the right cycle. Random thresholds and vectors, with some vectors repeated on purpose, then walk the block through every current stage and every winning position. Each run checks the committed code, the number of pulses and the cycle in which the pulse appears.

// File: rtl/sleep_stage_pkg.sv
package sleep_stage_pkg;

  localparam int NUM_STAGES = 5;
  localparam int NUM_CAND   = NUM_STAGES - 1;
  localparam int STEP_W     = $clog2(NUM_CAND);
  localparam int NUM_SLOTS  = NUM_STAGES * NUM_CAND;

  typedef enum logic [2:0] {
    ST_WAKE = 3'd0,
    ST_REM  = 3'd1,
    ST_N1   = 3'd2,
    ST_N2   = 3'd3,
    ST_N3   = 3'd4
  } stage_e;

  // Control-to-datapath strobes.
  typedef struct packed {
    logic capture;   // latch the incoming vector as the last accepted one
    logic evaluate;  // a pairwise test is being made this cycle
  } strobe_t;

  // Candidate tried at a given position of the sequence for a current stage.
  function automatic stage_e candidateAt(stage_e cur, logic [STEP_W-1:0] pos);
    stage_e c;
    c = ST_WAKE;
    unique case (cur)
      ST_WAKE: case (pos) 2'd0: c = ST_N1;   2'd1: c = ST_REM; 2'd2: c = ST_N2;  default: c = ST_N3;  endcase
      ST_REM:  case (pos) 2'd0: c = ST_WAKE; 2'd1: c = ST_N1;  2'd2: c = ST_N2;  default: c = ST_N3;  endcase
      ST_N1:   case (pos) 2'd0: c = ST_WAKE; 2'd1: c = ST_N2;  2'd2: c = ST_REM; default: c = ST_N3;  endcase
      ST_N2:   case (pos) 2'd0: c = ST_N1;   2'd1: c = ST_N3;  2'd2: c = ST_REM; default: c = ST_WAKE; endcase
      ST_N3:   case (pos) 2'd0: c = ST_N2;   2'd1: c = ST_N1;  2'd2: c = ST_WAKE; default: c = ST_REM; endcase
      default: c = ST_WAKE;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sleep_stage_dp.sv
module sleep_stage_dp
  import sleep_stage_pkg::*;
#(
  parameter int FEAT_W   = 12,
  parameter int NUM_FEAT = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       strobes,
  input  logic [FEAT_W*NUM_FEAT-1:0]    featVec,
  input  logic [FEAT_W*NUM_SLOTS-1:0]   thrVec,
  input  stage_e                        curStage,
  input  logic [STEP_W-1:0]             step,
  output logic                          featDiffers,
  output logic                          candWins,
  output stage_e                        candStage
);

  localparam int VEC_W = FEAT_W * NUM_FEAT;

  // The last accepted vector doubles as the working copy under test.
  logic [VEC_W-1:0]  heldVec;
  logic [FEAT_W-1:0] featFields [NUM_FEAT];
  logic [FEAT_W-1:0] thrSlots   [NUM_SLOTS];
  logic [FEAT_W-1:0] selFeat;
  logic [FEAT_W-1:0] selThr;
  int                featSel;
  int                slotSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldVec <= '0;
    end else if (strobes.capture) begin
      heldVec <= featVec;
    end
  end

  for (genvar f = 0; f < NUM_FEAT; f++) begin : g_field
    assign featFields[f] = heldVec[f*FEAT_W +: FEAT_W];
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign thrSlots[s] = thrVec[s*FEAT_W +: FEAT_W];
  end

  assign featDiffers = (featVec != heldVec);

  always_comb begin
    candStage = candidateAt(curStage, step);
    featSel   = int'(candStage) % NUM_FEAT;
    slotSel   = int'(curStage) * NUM_CAND + int'(step);
    if (slotSel >= NUM_SLOTS) slotSel = 0;
    selFeat   = featFields[featSel];
    selThr    = thrSlots[slotSel];
    candWins  = strobes.evaluate && (selFeat > selThr);
  end

endmodule

// File: rtl/sleep_stage_ctrl.sv
module sleep_stage_ctrl
  import sleep_stage_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              featValid,
  input  logic              featDiffers,
  input  logic              candWins,
  input  stage_e            candStage,
  output strobe_t           strobes,
  output stage_e            curStage,
  output logic [STEP_W-1:0] step,
  output logic              busy,
  output logic              stageChanged
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_CAND - 1);

  assign strobes.capture  = !busy && featValid;
  assign strobes.evaluate = busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy         <= 1'b0;
      step         <= '0;
      curStage     <= ST_WAKE;
      stageChanged <= 1'b0;
    end else begin
      stageChanged <= 1'b0;
      if (!busy) begin
        if (featValid && featDiffers) begin
          busy <= 1'b1;
          step <= '0;
        end
      end else if (candWins) begin
        curStage     <= candStage;
        stageChanged <= (candStage != curStage);
        busy         <= 1'b0;
      end else if (step == LAST_STEP) begin
        busy <= 1'b0;
      end else begin
        step <= step + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sleep_stager.sv
module sleep_stager
  import sleep_stage_pkg::*;
#(
  parameter int FEAT_W   = 12,
  parameter int NUM_FEAT = 4
) (
  input  logic                                      clk,
  input  logic                                      rstN,
  input  logic                                      featValid,
  input  logic [FEAT_W*NUM_FEAT-1:0]                featVec,
  input  logic [FEAT_W*NUM_STAGES*(NUM_STAGES-1)-1:0] thrVec,
  output logic [2:0]                                stage,
  output logic                                      stageChanged
);

  strobe_t           strobes;
  stage_e            curStage;
  stage_e            candStage;
  logic [STEP_W-1:0] step;
  logic              busy;
  logic              featDiffers;
  logic              candWins;

  sleep_stage_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .featValid    (featValid),
    .featDiffers  (featDiffers),
    .candWins     (candWins),
    .candStage    (candStage),
    .strobes      (strobes),
    .curStage     (curStage),
    .step         (step),
    .busy         (busy),
    .stageChanged (stageChanged)
  );

  sleep_stage_dp #(
    .FEAT_W   (FEAT_W),
    .NUM_FEAT (NUM_FEAT)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .featVec     (featVec),
    .thrVec      (thrVec),
    .curStage    (curStage),
    .step        (step),
    .featDiffers (featDiffers),
    .candWins    (candWins),
    .candStage   (candStage)
  );

  assign stage = curStage;

endmodule

// File: rtl/sleep_stager_chk.sv
module sleep_stager_chk (
  input logic       clk,
  input logic       rstN,
  input logic       featValid,
  input logic [2:0] stage,
  input logic       stageChanged,
  input logic       busy
);

  a_r2_code_range: assert property (@(posedge clk) disable iff (!rstN)
    stage <= 3'd4);

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    stageChanged |=> !stageChanged);

  a_r9_pulse_has_change: assert property (@(posedge clk) disable iff (!rstN)
    stageChanged |-> (stage != $past(stage)));

  a_r9_change_has_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (stage != $past(stage)) |-> stageChanged);

  a_r7_idle_holds_stage: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(stage));

  a_r3_start_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(featValid));

endmodule

bind sleep_stager sleep_stager_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .featValid    (featValid),
  .stage        (stage),
  .stageChanged (stageChanged),
  .busy         (busy)
);

// File: tb/sim_sleep_stager.sv
`timescale 1ns/1ps
module sim_sleep_stager;

  localparam int FW = 12;
  localparam int NF = 4;
  localparam int NS = 20;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           featValid = 1'b0;
  logic [FW*NF-1:0] featVec = '0;
  logic [FW*NS-1:0] thrVec;
  logic [2:0]     stage;
  logic           stageChanged;

  logic [FW-1:0]  thr [NS];
  logic [FW*NF-1:0] prevVec = '0;
  int             curStage = 0;
  int             nChecks = 0;
  int             nFail = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int s = 0; s < NS; s++) thrVec[s*FW +: FW] = thr[s];
  end

  sleep_stager u0 (
    .clk(clk), .rstN(rstN), .featValid(featValid), .featVec(featVec),
    .thrVec(thrVec), .stage(stage), .stageChanged(stageChanged)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Candidate order per current stage (R5).
  function automatic int orderOf(int cur, int pos);
    int t [5][4] = '{'{2,1,3,4}, '{0,2,3,4}, '{0,3,1,4}, '{2,4,1,0}, '{3,2,0,1}};
    return t[cur][pos];
  endfunction

  // First winning position, or -1 (R6).
  function automatic int winPos(int cur, logic [FW*NF-1:0] v);
    for (int p = 0; p < 4; p++) begin
      int k = orderOf(cur, p);
      if (v[(k % NF)*FW +: FW] > thr[cur*4+p]) return p;
    end
    return -1;
  endfunction

  task automatic setAllThr(input logic [FW-1:0] val);
    for (int s = 0; s < NS; s++) thr[s] = val;
  endtask

  task automatic runVec(input logic [FW*NF-1:0] v);
    int expPos, expStage, pulses, firstAt;
    bit accept;
    accept   = (v != prevVec);
    expPos   = accept ? winPos(curStage, v) : -1;
    expStage = (expPos >= 0) ? orderOf(curStage, expPos) : curStage;
    if (accept) prevVec = v;
    featVec = v; featValid = 1'b1;
    @(posedge clk); #1 featValid = 1'b0;
    pulses = 0; firstAt = -1;
    for (int i = 1; i <= 6; i++) begin
      @(posedge clk); #1;
      if (stageChanged) begin
        pulses++;
        if (firstAt < 0) firstAt = i;
      end
    end
    chk(stage == 3'(expStage), "R5 R6 committed stage", int'(stage), expStage);
    if (expPos >= 0 && expStage != curStage) begin
      chk(pulses == 1, "R9 pulse count", pulses, 1);
      chk(firstAt == expPos + 1, "R7 commit cycle", firstAt, expPos + 1);
    end else begin
      chk(pulses == 0, accept ? "R8 no win no pulse" : "R3 repeat ignored", pulses, 0);
    end
    curStage = expStage;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [FW*NF-1:0] vA, vB;
    void'($urandom(32'd1234));
    setAllThr('0);
    repeat (3) @(posedge clk);
    #1;
    chk(stage == 3'd0, "R1 reset stage", int'(stage), 0);
    chk(stageChanged == 1'b0, "R1 reset pulse", int'(stageChanged), 0);
    rstN = 1'b1;
    @(posedge clk); #1;
    chk(stage == 3'd0 && stageChanged == 1'b0, "R1 after release", int'(stage), 0);

    // R3: all-zero vector equals the reset copy, so nothing happens despite zero thresholds.
    runVec('0);
    // Any accepted nonzero vector wins position 0 from Wake -> N1 (R5, R7).
    runVec({NF{12'hFFF}});
    chk(stage == 3'd2, "R2 N1 code", int'(stage), 2);
    // R3: same vector again from N1: no reclassification.
    runVec({NF{12'hFFF}});

    // R8: thresholds at maximum, nobody can win.
    setAllThr('1);
    runVec({12'h100, 12'h200, 12'h300, 12'h400});

    // R4: a vector strobed mid-run is dropped.
    vA = {12'h011, 12'h022, 12'h033, 12'h044};
    vB = {12'h0AA, 12'h0BB, 12'h0CC, 12'h0DD};
    featVec = vA; featValid = 1'b1;
    @(posedge clk); #1 featValid = 1'b0;
    prevVec = vA;
    @(posedge clk); #1;
    featVec = vB; featValid = 1'b1;
    @(posedge clk); #1 featValid = 1'b0;
    repeat (6) @(posedge clk);
    #1;
    chk(stage == 3'd2, "R4 stage held through dropped strobe", int'(stage), 2);
    // Open slot N1 pos0 (Wake, field 0); B differs from A, so it must classify.
    thr[2*4+0] = '0;
    runVec(vB);
    chk(stage == 3'd0, "R4 dropped vector not recorded", int'(stage), 0);

    // R5 R6: only Wake position 1 (REM, field 1) open.
    setAllThr('1);
    thr[0*4+1] = 12'h010;
    runVec({12'h0, 12'h0, 12'h011, 12'h0});
    chk(stage == 3'd1, "R5 REM at position 1", int'(stage), 1);
    // R6 strict compare: field equal to threshold does not win.
    thr[1*4+0] = 12'h050;
    runVec({12'h0, 12'h0, 12'h0, 12'h050});

    // Random rounds.
    for (int r = 0; r < 16; r++) begin
      for (int s = 0; s < NS; s++) thr[s] = 12'($urandom_range(0, 4095));
      for (int n = 0; n < 10; n++) begin
        logic [FW*NF-1:0] v;
        if ($urandom_range(0, 3) == 0) v = prevVec;
        else for (int f = 0; f < NF; f++) v[f*FW +: FW] = 12'($urandom_range(0, 4095));
        runVec(v);
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule